// File: doc/BRIEF.md
# Read-Protected Three-Slot Bank Mapper

This block sits between a 24-bit CPU bus and a cartridge ROM. After reset the ROM is locked. Every 64 KiB window below 4 MiB then shows only the first 32 KiB of ROM, repeated. Byte reads inside the 64 KiB window at 0x010000 also have their byte lane swapped. A small down-counter tracks these window reads. When it reaches zero the lock lifts and the ROM appears in its normal layout. The bottom 2.5 MiB map one to one. The three 512 KiB slots at 0x280000, 0x300000 and 0x380000 each show a ROM bank that software selects.

Software programs the block through a 256-byte register page at 0xA13000. The page holds a control register, three bank registers and a byte port to a serial EEPROM. A bank register moves its slot only while the enable bit of the control register is set. The moment the lock lifts, the latched bank registers are applied. The block puts out the translated ROM address, a lane-swap flag and the EEPROM strobes. The ROM array, the EEPROM and the CPU are outside the block.

Top module: `prot_bank_mapper`

## Requirements
- R1: Reset loads control register 0x01, bank registers 0 and a lock count of 3 (locked). Every slot mapping is bank 0. The EEPROM write strobe is low.
- R2: A byte write anywhere in the page whose address low nibble is n stores the data in register n>>1 (0 control, 1 to 3 banks), even for an even address. Only the odd addresses 3, 5, 7 and 9 cause any further action.
- R3: A word write at page address A behaves exactly like a byte write of the low data byte to address A|1.
- R4: With control bit 1 set, a byte write to offset 3, 5 or 7 moves slot 0x280000, 0x300000 or 0x380000 to ROM bank `data` (ROM address = data*0x80000 + offset in slot). This is visible from the next cycle. With bit 1 clear, the slot keeps its mapping.
- R5: A bank value not below ROM_BANKS (8) leaves the slot's mapping unchanged.
- R6: A byte write to offset 9 raises `eeWrStb` for exactly the next cycle, with `eeWrData` equal to the written byte.
- R7: A byte read of exactly 0xA1300B raises `eeRdStb` in the same cycle and returns `eeRdData` on `regRdData`. Every other read gives `regRdData` = 0.
- R8: Each byte read in 0x010000 to 0x01FFFF lowers a nonzero lock count by one. Word reads and reads elsewhere leave it unchanged. The third such read unlocks.
- R9: While locked, a read below 4 MiB gives `romAddr` = A & 0x7FFF. A byte read in 0x010000 to 0x01FFFF instead gives (A & 0x7FFF) ^ 1, with `laneSwap` = 1. In every other case `laneSwap` = 0.
- R10: While unlocked, reads in 0x000000 to 0x27FFFF give `romAddr` = A.
- R11: The read that unlocks still uses the locked mapping. From the next cycle, each slot shows its latched bank register whatever control bit 1 is, except where R5 rejects the value.
- R12: `romHit` is high only for a read with an address below 0x400000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 24 | CPU byte address |
| cpuRdEn | input | 1 | Read access this cycle |
| cpuWrEn | input | 1 | Write access this cycle (never with cpuRdEn) |
| cpuWord | input | 1 | Access is 16-bit |
| cpuWrData | input | 8 | Write byte (low byte of a word write) |
| eeRdData | input | 8 | Byte offered by the EEPROM port |
| romAddr | output | 22 | Translated ROM byte address |
| romHit | output | 1 | Read targets ROM space |
| laneSwap | output | 1 | Byte taken from the opposite lane |
| regRdData | output | 8 | Read data for the register page |
| eeWrStb | output | 1 | EEPROM write strobe |
| eeWrData | output | 8 | EEPROM write byte |
| eeRdStb | output | 1 | EEPROM read strobe |

## Verification
Some properties are checked on every cycle by assertions:
- the lock count never rises and stays put without a window byte read;
- slot mappings hold when no load is strobed;
- the unlock cycle loads every slot;
- a swapped byte always lands inside the 32 KiB copy;
- EEPROM writes follow a CPU write;
- page reads return zero except at the EEPROM offset;
- low addresses are linear once unlocked.

Other behaviour shows only in scenarios: the gating by control bit 1, the rejection of out-of-range banks, storage through even addresses and word writes, and the exact count of reads that unlocks. The bench drives directed sequences and seeded random traffic and compares every read against its own model of the registers and the lock.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int SLOT_CNT = 3;
  localparam int FIRST_SLOT = 8 - SLOT_CNT;   // slots fill the top of the 4 MiB space
  localparam int GATE_BIT = 1;
  localparam logic [3:0] EE_WR_LOW = 4'h9;
  localparam logic [7:0] EE_RD_OFS = 8'h0B;

  typedef struct packed {
    logic [SLOT_CNT-1:0]       slotLoad;
    logic [SLOT_CNT-1:0][7:0]  slotVal;
    logic                      eeWr;
    logic [7:0]                eeData;
    logic                      eeRd;
    logic                      protOn;
    logic                      winByteRd;
  } pbm_strobe_t;
endpackage

// File: rtl/pbm_control.sv
module pbm_control
  import pbm_pkg::*;
#(
  parameter logic [15:0] PAGE_ID    = 16'hA130,
  parameter logic [7:0]  PROT_WIN   = 8'h01,
  parameter int          PROT_READS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [23:0] cpuAddr,
  input  logic        cpuRdEn,
  input  logic        cpuWrEn,
  input  logic        cpuWord,
  input  logic [7:0]  cpuWrData,
  output pbm_strobe_t stb
);
  localparam int CNT_W = $clog2(PROT_READS + 1);
  localparam int NREG  = SLOT_CNT + 1;

  logic [NREG-1:0][7:0] regQ;
  logic [CNT_W-1:0]     cntQ;
  logic [3:0]           effLow;
  logic                 pageHit, wrPage, protRead, unlockNow;

  assign pageHit   = cpuAddr[23:8] == PAGE_ID;
  assign effLow    = cpuWord ? {cpuAddr[3:1], 1'b1} : cpuAddr[3:0];
  assign wrPage    = cpuWrEn && pageHit;
  assign protRead  = cpuRdEn && !cpuWord && (cpuAddr[23:16] == PROT_WIN);
  assign unlockNow = protRead && (cntQ == CNT_W'(1));

  // register file: index is the low nibble halved
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regQ[i] <= (i == 0) ? 8'h01 : 8'h00;
    end else if (wrPage) begin
      for (int i = 0; i < NREG; i++)
        if (effLow[3:1] == 3'(i)) regQ[i] <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      cntQ <= CNT_W'(PROT_READS);
    else if (protRead && cntQ != 0) cntQ <= cntQ - CNT_W'(1);
  end

  always_comb begin
    stb = '0;
    for (int s = 0; s < SLOT_CNT; s++) begin
      stb.slotVal[s] = regQ[s + 1];
      if (wrPage && regQ[0][GATE_BIT] && effLow == 4'(2 * s + 3)) begin
        stb.slotLoad[s] = 1'b1;
        stb.slotVal[s]  = cpuWrData;
      end else if (unlockNow) begin
        stb.slotLoad[s] = 1'b1;
      end
    end
    stb.eeWr      = wrPage && (effLow == EE_WR_LOW);
    stb.eeData    = cpuWrData;
    stb.eeRd      = cpuRdEn && !cpuWord && pageHit && (cpuAddr[7:0] == EE_RD_OFS);
    stb.protOn    = cntQ != 0;
    stb.winByteRd = protRead;
  end

  assert_prot_count_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdEn |=> cntQ <= $past(cntQ));
  assert_prot_count_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !protRead |=> $stable(cntQ));
endmodule

// File: rtl/pbm_datapath.sv
module pbm_datapath
  import pbm_pkg::*;
#(
  parameter int ROM_BANKS = 8,
  parameter int BANK_IW   = $clog2(ROM_BANKS),
  parameter int ROM_AW    = 19 + BANK_IW
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbm_strobe_t       stb,
  input  logic [23:0]       cpuAddr,
  input  logic              cpuRdEn,
  input  logic [7:0]        eeRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romHit,
  output logic              laneSwap,
  output logic [7:0]        regRdData,
  output logic              eeWrStb,
  output logic [7:0]        eeWrData,
  output logic              eeRdStb
);
  logic [SLOT_CNT-1:0][BANK_IW-1:0] mapBank;
  logic [2:0] slotIdx;

  generate
    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) mapBank[s] <= '0;
        else if (stb.slotLoad[s] && (32'(stb.slotVal[s]) < ROM_BANKS))
          mapBank[s] <= BANK_IW'(stb.slotVal[s]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eeWrStb  <= 1'b0;
      eeWrData <= 8'h00;
    end else begin
      eeWrStb  <= stb.eeWr;
      if (stb.eeWr) eeWrData <= stb.eeData;
    end
  end

  assign romHit    = cpuRdEn && (cpuAddr[23:22] == 2'b00);
  assign laneSwap  = romHit && stb.protOn && stb.winByteRd;
  assign slotIdx   = cpuAddr[21:19];
  assign eeRdStb   = stb.eeRd;
  assign regRdData = stb.eeRd ? eeRdData : 8'h00;

  always_comb begin
    romAddr = ROM_AW'(cpuAddr[21:0]);
    if (stb.protOn) begin
      romAddr = ROM_AW'({cpuAddr[14:1], cpuAddr[0] ^ laneSwap});
    end else begin
      for (int s = 0; s < SLOT_CNT; s++)
        if (slotIdx == 3'(FIRST_SLOT + s)) romAddr = {mapBank[s], cpuAddr[18:0]};
    end
  end

  assert_idle_slots_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.slotLoad == '0) |=> $stable(mapBank));
  assert_unlock_loads_all_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.protOn) |-> $past(stb.slotLoad) == {SLOT_CNT{1'b1}});
  assert_swap_low_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    laneSwap |-> romAddr < ROM_AW'(32'h8000));
endmodule

// File: rtl/prot_bank_mapper.sv
module prot_bank_mapper
  import pbm_pkg::*;
#(
  parameter logic [15:0] PAGE_ID    = 16'hA130,
  parameter int          PROT_READS = 3,
  parameter int          ROM_BANKS  = 8,
  parameter int          ROM_AW     = 19 + $clog2(ROM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [23:0]       cpuAddr,
  input  logic              cpuRdEn,
  input  logic              cpuWrEn,
  input  logic              cpuWord,
  input  logic [7:0]        cpuWrData,
  input  logic [7:0]        eeRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romHit,
  output logic              laneSwap,
  output logic [7:0]        regRdData,
  output logic              eeWrStb,
  output logic [7:0]        eeWrData,
  output logic              eeRdStb
);
  pbm_strobe_t stb;

  pbm_control #(.PAGE_ID(PAGE_ID), .PROT_WIN(8'h01), .PROT_READS(PROT_READS)) u_control (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRdEn(cpuRdEn), .cpuWrEn(cpuWrEn),
    .cpuWord(cpuWord), .cpuWrData(cpuWrData), .stb(stb)
  );

  pbm_datapath #(.ROM_BANKS(ROM_BANKS), .BANK_IW($clog2(ROM_BANKS)), .ROM_AW(ROM_AW)) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuAddr(cpuAddr), .cpuRdEn(cpuRdEn),
    .eeRdData(eeRdData), .romAddr(romAddr), .romHit(romHit), .laneSwap(laneSwap),
    .regRdData(regRdData), .eeWrStb(eeWrStb), .eeWrData(eeWrData), .eeRdStb(eeRdStb)
  );

  assert_ee_write_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    eeWrStb |-> $past(cpuWrEn));
  assert_page_read_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && cpuAddr[23:8] == PAGE_ID && cpuAddr[7:0] != EE_RD_OFS) |-> regRdData == 8'h00);
  assert_linear_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (romHit && !stb.protOn && cpuAddr < 24'h280000) |-> romAddr == ROM_AW'(cpuAddr[21:0]));
endmodule

// File: tb/prot_bank_mapper_bench.sv
`timescale 1ns/1ps
module prot_bank_mapper_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic cpuRdEn = 0, cpuWrEn = 0, cpuWord = 0;
  logic [7:0] cpuWrData = '0, eeRdData = '0;
  logic [21:0] romAddr;
  logic romHit, laneSwap, eeWrStb, eeRdStb;
  logic [7:0] regRdData, eeWrData;

  always #4 clk = ~clk;   // 125 MHz

  prot_bank_mapper u_prot_bank_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRdEn(cpuRdEn), .cpuWrEn(cpuWrEn),
    .cpuWord(cpuWord), .cpuWrData(cpuWrData), .eeRdData(eeRdData), .romAddr(romAddr),
    .romHit(romHit), .laneSwap(laneSwap), .regRdData(regRdData), .eeWrStb(eeWrStb),
    .eeWrData(eeWrData), .eeRdStb(eeRdStb)
  );

  int nChecks = 0, nErr = 0;
  bit finished = 0;
  logic [7:0] mRegs [4];
  int mMap [3];
  int mCnt;
  bit mPendEe;
  logic [7:0] mEeData;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] expRom(input logic [23:0] a, input bit word);
    logic [21:0] r;
    int s;
    if (mCnt != 0) begin
      r = 22'(a & 24'h7FFF);
      if (!word && a[23:16] == 8'h01) r[0] = ~r[0];
    end else begin
      s = int'(a[21:19]);
      if (s >= 5) r = {3'(mMap[s-5]), a[18:0]};
      else        r = a[21:0];
    end
    return r;
  endfunction

  task automatic modelReset();
    mRegs[0] = 8'h01; mRegs[1] = 0; mRegs[2] = 0; mRegs[3] = 0;
    for (int i = 0; i < 3; i++) mMap[i] = 0;
    mCnt = 3; mPendEe = 0; mEeData = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; cpuRdEn = 0; cpuWrEn = 0; cpuWord = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  task automatic doOp(input string tag, input bit rd, input bit wr, input bit word,
                      input logic [23:0] addr, input logic [7:0] data);
    logic [3:0] eff;
    bit page, expHit, expEe, expSwap;
    @(negedge clk);
    cpuAddr = addr; cpuRdEn = rd; cpuWrEn = wr; cpuWord = word; cpuWrData = data;
    eeRdData = 8'($urandom);
    #1;
    chk({tag, " eeWrStb"}, 32'(eeWrStb), 32'(mPendEe));
    if (mPendEe) chk({tag, " eeWrData"}, 32'(eeWrData), 32'(mEeData));
    page    = addr[23:8] == 16'hA130;
    expHit  = rd && addr[23:22] == 2'b00;
    expEe   = rd && !word && page && addr[7:0] == 8'h0B;
    expSwap = expHit && mCnt != 0 && !word && addr[23:16] == 8'h01;
    chk({tag, " romHit"}, 32'(romHit), 32'(expHit));
    chk({tag, " laneSwap"}, 32'(laneSwap), 32'(expSwap));
    if (expHit) chk({tag, " romAddr"}, 32'(romAddr), 32'(expRom(addr, word)));
    chk({tag, " eeRdStb"}, 32'(eeRdStb), 32'(expEe));
    chk({tag, " regRdData"}, 32'(regRdData), expEe ? 32'(eeRdData) : 32'h0);
    @(posedge clk);
    mPendEe = 0;
    if (wr && page) begin
      eff = word ? {addr[3:1], 1'b1} : addr[3:0];
      if ((eff == 4'h3 || eff == 4'h5 || eff == 4'h7) && mRegs[0][1] && data < 8)
        mMap[(int'(eff) - 3) / 2] = int'(data);
      if (eff[3:1] < 4) mRegs[eff[3:1]] = data;
      if (eff == 4'h9) begin mPendEe = 1; mEeData = data; end
    end
    if (rd && !word && addr[23:16] == 8'h01 && mCnt > 0) begin
      mCnt--;
      if (mCnt == 0)
        for (int i = 0; i < 3; i++) if (mRegs[i+1] < 8) mMap[i] = int'(mRegs[i+1]);
    end
  endtask

  task automatic sampleNow(input string tag, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk); #1; chk(tag, act, exp);
  endtask

  task automatic randomPhase(input int n);
    int r;
    for (int k = 0; k < n; k++) begin
      r = $urandom_range(0, 9);
      if (r <= 3)
        doOp("random write", 0, 1, $urandom_range(0, 3) == 0,
             {16'hA130, 4'h0, 4'($urandom)}, 8'($urandom_range(0, 11)));
      else if (r <= 6)
        doOp("random window read", 1, 0, $urandom_range(0, 4) == 0,
             {8'h01, 16'($urandom)}, 8'h00);
      else if (r == 7)
        doOp("random page read", 1, 0, $urandom_range(0, 3) == 0,
             {16'hA130, 8'($urandom_range(0, 15))}, 8'h00);
      else
        doOp("random read", 1, 0, $urandom_range(0, 1) == 1,
             24'($urandom) & 24'h7FFFFF, 8'h00);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    doReset();
    // R1: reset state
    doOp("R1 idle", 0, 0, 0, 24'h0, 8'h00);
    doOp("R1 locked read", 1, 0, 1, 24'h000100, 8'h00);
    chk("R1 romAddr literal", 32'(romAddr), 32'h100);
    // R9: locked windows and swap
    doOp("R9 swap read", 1, 0, 0, 24'h012345, 8'h00);
    doOp("R9 high locked read", 1, 0, 1, 24'h2A1234, 8'h00);
    sampleNow("R9 copy window", 32'(romAddr), 32'h1234);
    // R8: word and outside reads do not count
    doOp("R8 word window read", 1, 0, 1, 24'h015000, 8'h00);
    doOp("R8 outside read", 1, 0, 0, 24'h020000, 8'h00);
    // R4: gate clear, bank register latched only
    doOp("R4 gated write", 0, 1, 0, 24'hA13003, 8'h04);
    // R6: EEPROM write strobe
    doOp("R6 ee write", 0, 1, 0, 24'hA13009, 8'h5A);
    doOp("R6 ee strobe", 0, 0, 0, 24'h0, 8'h00);
    // R7: EEPROM read and zero page reads
    doOp("R7 ee read", 1, 0, 0, 24'hA1300B, 8'h00);
    doOp("R7 zero read", 1, 0, 0, 24'hA13005, 8'h00);
    // R3: word write acts on odd byte; R2: even address stores
    doOp("R3 word write", 0, 1, 1, 24'hA13004, 8'h02);
    doOp("R2 even write", 0, 1, 0, 24'hA13006, 8'h01);
    // R8: count down to unlock
    doOp("R8 second window read", 1, 0, 0, 24'h010000, 8'h00);
    doOp("R8 still locked", 1, 0, 1, 24'h000200, 8'h00);
    doOp("R11 unlocking read", 1, 0, 0, 24'h01FFFF, 8'h00);
    // R11: latched banks applied
    doOp("R11 slot1", 1, 0, 1, 24'h280010, 8'h00);
    sampleNow("R11 slot1 literal", 32'(romAddr), 32'h200010);
    doOp("R3 slot2", 1, 0, 1, 24'h300004, 8'h00);
    sampleNow("R3 slot2 literal", 32'(romAddr), 32'h100004);
    doOp("R2 slot3", 1, 0, 1, 24'h380020, 8'h00);
    sampleNow("R2 slot3 literal", 32'(romAddr), 32'h080020);
    // R10: linear low space, no swap
    doOp("R10 linear", 1, 0, 1, 24'h123456, 8'h00);
    sampleNow("R10 linear literal", 32'(romAddr), 32'h123456);
    doOp("R10 window unswapped", 1, 0, 0, 24'h010001, 8'h00);
    // R4: gate set
    doOp("R4 enable", 0, 1, 0, 24'hA13001, 8'h03);
    doOp("R4 slot3 write", 0, 1, 0, 24'hA13007, 8'h03);
    doOp("R4 slot3 read", 1, 0, 1, 24'h380008, 8'h00);
    sampleNow("R4 slot3 literal", 32'(romAddr), 32'h180008);
    // R5: out-of-range bank rejected
    doOp("R5 bad bank", 0, 1, 0, 24'hA13003, 8'h08);
    doOp("R5 slot1 kept", 1, 0, 1, 24'h280010, 8'h00);
    sampleNow("R5 slot1 literal", 32'(romAddr), 32'h200010);
    // R4: gate cleared again
    doOp("R4 disable", 0, 1, 0, 24'hA13001, 8'h01);
    doOp("R4 blocked write", 0, 1, 0, 24'hA13005, 8'h00);
    doOp("R4 slot2 kept", 1, 0, 1, 24'h300004, 8'h00);
    // R12: outside ROM space
    doOp("R12 high read", 1, 0, 1, 24'h400000, 8'h00);
    doOp("R12 page read", 1, 0, 0, 24'hA13001, 8'h00);
    randomPhase(400);
    doReset();
    randomPhase(600);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule